// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several software localities owns a shared register window. Each locality has a 4 KB page, and the page number is taken from the write address above the page offset. A byte write to offset zero of a page is a write to that locality's access byte. The block keeps one owner or none, along with per-locality request, seize and been-seized flags. It exposes the read value of every access byte at all times.

Ownership moves in three ways:
- The owner lets go, and the highest-numbered requester takes over.
- A higher-numbered locality seizes it.
- An idle interface is claimed outright.

If a command engine reports that it is busy when a move is due, the block does not switch at once. It raises a one-cycle abort request and performs the move only when the engine answers with its abort-done strobe. Every real change of owner produces a one-cycle owner-changed pulse. All control pins are plain level or pulse signals; the block has no stream interface and applies no back-pressure.

Top module: `loc_arbiter`

## Requirements
- R1: After reset, no locality owns the interface (`owner` reads 0xFF), no abort is pending, and every access byte reads 0x80.
- R2: Access byte layout: bit 7 valid (always 1), bit 5 owner, bit 4 been-seized, bit 3 seize (write-only, always reads 0), bit 2 pending (1 when any other locality has request-use set), bit 1 request-use, bits 6 and 0 read 0. At most one locality reads bit 5 set.
- R3: Writing bit 1 from a locality while nobody owns the interface makes that locality the owner at once.
- R4: Writing bit 1 from a non-owner while another locality owns the interface sets that locality's request-use; the owner's own bit-1 write does nothing.
- R5: Writing bit 5 from the owner releases the interface to the highest-numbered locality with request-use set, or to nobody (0xFF) when none is set.
- R6: Writing bit 5 from a non-owner clears only that locality's request-use.
- R7: A seize (bit 3) is accepted only when nobody owns the interface or the writer's number is above the owner's. It is refused when the writer already has one pending or a higher locality has one pending. An accepted seize cancels pending seizes of lower localities.
- R8: An owner displaced by a seize loses ownership, keeps its request-use and gets been-seized. Writing 1 to bit 4 clears been-seized.
- R9: A new owner has request-use and seize cleared. `owner_changed` pulses in the cycle after any write or abort-done that changes the owner.
- R10: If `cmd_busy` is high when a release or seize would move ownership, `abort_req` pulses for one cycle and ownership stays put until `abort_done`. The move then takes effect in the cycle after the strobe.
- R11: Writes are ignored when they target locality 4's page, a page number of 5 or above, or a nonzero page offset.
- R12: In a write with bit 3 set, bits 1 and 5 of the same byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W (15) | Write address; bits [14:12] select the locality |
| wr_data | input | 8 | Byte written to the access register |
| cmd_busy | input | 1 | Command engine is executing |
| abort_done | input | 1 | Command engine finished the requested abort |
| acc_rdata | output | NUM_LOC*8 (40) | Read value of each locality's access byte, locality i at [8i+7:8i] |
| owner | output | 8 | Current owning locality, 0xFF for none |
| owner_changed | output | 1 | One-cycle pulse on a change of owner |
| abort_req | output | 1 | One-cycle abort request toward the command engine |

## Verification
The directed part walks through the following cases:
- an idle claim, queued requests and a release that picks the highest requester, which separates highest-wins from first-come order;
- a non-owner release;
- a seize from below that is refused, and one from above that is accepted, which separates R7 from R5;
- ignored pages and offsets;
- a busy release that has to wait for `abort_done`;
- contending seizes under a busy engine, which checks cancellation of lower seizes against refusal under a higher one.

The random part then mixes all flag combinations, out-of-range pages, busy levels and stray `abort_done` strobes. That exposes ordering faults between a completion and a write arriving in the same cycle.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int BIT_REQ    = 1;
  localparam int BIT_PEND   = 2;
  localparam int BIT_SEIZE  = 3;
  localparam int BIT_SEIZED = 4;
  localparam int BIT_ACT    = 5;
  localparam int BIT_VALID  = 7;
  localparam logic [7:0] NO_OWNER = 8'hFF;
endpackage

// File: rtl/lar_addr_dec.sv
module lar_addr_dec #(
  parameter int ADDR_W  = 15,
  parameter int PAGE_W  = 12,
  parameter int NUM_LOC = 5,
  parameter int RO_LOC  = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit,
  output logic [7:0]        loc
);
  localparam logic [7:0] NUM_LOC8 = 8'(NUM_LOC);
  localparam logic [7:0] RO_LOC8  = 8'(RO_LOC);

  always_comb begin
    loc = 8'(wr_addr[ADDR_W-1:PAGE_W]);
    hit = wr_en && (wr_addr[PAGE_W-1:0] == '0) &&
          (loc < NUM_LOC8) && (loc != RO_LOC8);
  end
endmodule

// File: rtl/lar_prio_pick.sv
module lar_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [7:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = lar_pkg::NO_OWNER;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = 8'(i);
      end
    end
  end
endmodule

// File: rtl/lar_read_view.sv
module lar_read_view #(
  parameter int N = 5
) (
  input  logic [N-1:0]   req,
  input  logic [N-1:0]   seized,
  input  logic [7:0]     owner,
  output logic [N*8-1:0] rdata
);
  import lar_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_loc
    logic       pend;
    logic [7:0] b;
    always_comb begin
      pend = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != g && req[j]) pend = 1'b1;
      end
      b             = '0;
      b[BIT_VALID]  = 1'b1;
      b[BIT_ACT]    = (owner == 8'(g));
      b[BIT_SEIZED] = seized[g];
      b[BIT_PEND]   = pend;
      b[BIT_REQ]    = req[g];
    end
    assign rdata[g*8 +: 8] = b;
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int PAGE_W  = 12,
  parameter int RO_LOC  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 cmd_busy,
  input  logic                 abort_done,
  output logic [NUM_LOC*8-1:0] acc_rdata,
  output logic [7:0]           owner,
  output logic                 owner_changed,
  output logic                 abort_req
);
  import lar_pkg::*;

  localparam int LOC_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;

  typedef struct packed {
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] seize;
    logic [NUM_LOC-1:0] seized;
    logic [7:0]         act;
    logic               chg;
    logic               pend;
    logic [7:0]         nxt;
    logic               abt;
  } st_t;

  // Move ownership to n, applying seize/release side effects to the old owner.
  function automatic st_t xfer(st_t s, logic [7:0] n);
    st_t  r;
    logic sz;
    logic change;
    r      = s;
    sz     = 1'b0;
    change = (s.act != n);
    if (change && s.act != NO_OWNER) begin
      sz = (n != NO_OWNER) && s.seize[n[LOC_W-1:0]];
      if (sz) r.seized[s.act[LOC_W-1:0]] = 1'b1;
      else    r.req[s.act[LOC_W-1:0]]    = 1'b0;
    end
    r.act = n;
    if (n != NO_OWNER) begin
      r.req[n[LOC_W-1:0]]   = 1'b0;
      r.seize[n[LOC_W-1:0]] = 1'b0;
    end
    if (change) r.chg = 1'b1;
    return r;
  endfunction

  // Either defer the move behind an abort, or do it now.
  function automatic st_t prep(st_t s, logic [7:0] n, logic busy);
    st_t r;
    if (busy) begin
      r      = s;
      r.pend = 1'b1;
      r.nxt  = n;
      r.abt  = 1'b1;
    end else begin
      r = xfer(s, n);
    end
    return r;
  endfunction

  st_t        cur;
  st_t        s_done;
  st_t        s_nxt;
  logic       hit;
  logic [7:0] wloc;
  logic       pick_found;
  logic [7:0] pick_idx;

  lar_addr_dec #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .NUM_LOC(NUM_LOC),
    .RO_LOC (RO_LOC)
  ) dec_i (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .hit    (hit),
    .loc    (wloc)
  );

  // Stage 1: a finished abort completes the deferred move.
  always_comb begin
    s_done     = cur;
    s_done.chg = 1'b0;
    s_done.abt = 1'b0;
    if (cur.pend && abort_done) begin
      s_done      = xfer(s_done, cur.nxt);
      s_done.pend = 1'b0;
      s_done.nxt  = NO_OWNER;
    end
  end

  lar_prio_pick #(.N(NUM_LOC)) pick_i (
    .vec  (s_done.req),
    .found(pick_found),
    .idx  (pick_idx)
  );

  // Stage 2: apply the access-byte write, in release/clear/seize/request order.
  logic [7:0]       d;
  logic [7:0]       newa;
  logic             setnew;
  logic             higher;
  logic [LOC_W-1:0] wi;

  always_comb begin
    s_nxt  = s_done;
    d      = wr_data;
    newa   = s_done.act;
    setnew = 1'b1;
    higher = 1'b0;
    wi     = wloc[LOC_W-1:0];
    if (d[BIT_SEIZE]) begin
      d[BIT_REQ] = 1'b0;
      d[BIT_ACT] = 1'b0;
    end
    if (hit) begin
      if (d[BIT_ACT]) begin
        if (s_nxt.act == wloc) begin
          if (pick_found) begin
            setnew = 1'b0;
            s_nxt  = prep(s_nxt, pick_idx, cmd_busy);
          end else begin
            newa = NO_OWNER;
          end
        end else begin
          s_nxt.req[wi] = 1'b0;
        end
      end
      if (d[BIT_SEIZED]) s_nxt.seized[wi] = 1'b0;
      if (d[BIT_SEIZE]) begin
        for (int j = 0; j < NUM_LOC; j++) begin
          if (8'(j) > wloc && s_nxt.seize[j]) higher = 1'b1;
        end
        if ((s_nxt.act == NO_OWNER || wloc > s_nxt.act) &&
            !s_nxt.seize[wi] && !higher) begin
          for (int j = 0; j < NUM_LOC; j++) begin
            if (8'(j) < wloc) s_nxt.seize[j] = 1'b0;
          end
          s_nxt.seize[wi] = 1'b1;
          setnew = 1'b0;
          s_nxt  = prep(s_nxt, wloc, cmd_busy);
        end
      end
      if (d[BIT_REQ] && s_nxt.act != wloc) begin
        if (s_nxt.act != NO_OWNER) s_nxt.req[wi] = 1'b1;
        else                       newa = wloc;
      end
      if (setnew) s_nxt = xfer(s_nxt, newa);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur.req    <= '0;
      cur.seize  <= '0;
      cur.seized <= '0;
      cur.act    <= NO_OWNER;
      cur.chg    <= 1'b0;
      cur.pend   <= 1'b0;
      cur.nxt    <= NO_OWNER;
      cur.abt    <= 1'b0;
    end else begin
      cur <= s_nxt;
    end
  end

  lar_read_view #(.N(NUM_LOC)) view_i (
    .req   (cur.req),
    .seized(cur.seized),
    .owner (cur.act),
    .rdata (acc_rdata)
  );

  assign owner         = cur.act;
  assign owner_changed = cur.chg;
  assign abort_req     = cur.abt;

  // ---------------- assertions ----------------
  logic [NUM_LOC-1:0] act_bits;
  always_comb begin
    for (int i = 0; i < NUM_LOC; i++) act_bits[i] = acc_rdata[i*8 + BIT_ACT];
  end

  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_bits));

  p_owner_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == NO_OWNER) || (owner < 8'(NUM_LOC)));

  p_seize_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur.seize));

  p_change_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner)) |-> owner_changed);

  p_new_owner_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner) && owner != NO_OWNER) |-> !cur.req[owner[LOC_W-1:0]]);

  p_abort_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(cmd_busy));

  p_ro_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1:PAGE_W] == (ADDR_W-PAGE_W)'(RO_LOC) &&
     !(cur.pend && abort_done)) |=> ($stable(owner) && $stable(acc_rdata)));
endmodule

// File: tb/loc_arbiter_tb_top.sv
module loc_arbiter_tb_top;
  localparam int N = 5;
  localparam logic [7:0] NONE = 8'hFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [14:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          cmd_busy = 1'b0;
  logic          abort_done = 1'b0;
  logic [N*8-1:0] acc_rdata;
  logic [7:0]    owner;
  logic          owner_changed;
  logic          abort_req;

  always #2 clk = ~clk;

  loc_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_busy(cmd_busy), .abort_done(abort_done),
    .acc_rdata(acc_rdata), .owner(owner), .owner_changed(owner_changed),
    .abort_req(abort_req)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [N-1:0] m_req, m_seize, m_seized;
  logic [7:0]   m_act, m_next;
  logic         m_pend, m_chg, m_abt;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic m_xfer(logic [7:0] n);
    bit sz;
    bit ch;
    ch = (m_act != n);
    if (ch && m_act != NONE) begin
      sz = (n != NONE) && m_seize[n];
      if (sz) m_seized[m_act] = 1'b1;
      else    m_req[m_act] = 1'b0;
    end
    m_act = n;
    if (n != NONE) begin
      m_req[n] = 1'b0;
      m_seize[n] = 1'b0;
    end
    if (ch) m_chg = 1'b1;
  endtask

  task automatic m_prep(logic [7:0] n, bit busy);
    if (busy) begin
      m_pend = 1'b1; m_next = n; m_abt = 1'b1;
    end else m_xfer(n);
  endtask

  task automatic m_write(int loc, logic [7:0] d, bit busy);
    logic [7:0] l8;
    logic [7:0] newa;
    bit setnew;
    bit hi;
    bit found;
    int top;
    l8 = 8'(loc);
    newa = m_act;
    setnew = 1;
    if (d[3]) begin d[1] = 0; d[5] = 0; end  // R12
    if (d[5]) begin
      if (m_act == l8) begin
        found = 0; top = 0;
        for (int i = 0; i < N; i++) if (m_req[i]) begin found = 1; top = i; end
        if (found) begin setnew = 0; m_prep(8'(top), busy); end
        else newa = NONE;
      end else m_req[loc] = 1'b0;
    end
    if (d[4]) m_seized[loc] = 1'b0;
    if (d[3]) begin
      hi = 0;
      for (int i = loc + 1; i < N; i++) if (m_seize[i]) hi = 1;
      if ((m_act == NONE || l8 > m_act) && !m_seize[loc] && !hi) begin
        for (int i = 0; i < loc; i++) m_seize[i] = 1'b0;
        m_seize[loc] = 1'b1;
        setnew = 0;
        m_prep(l8, busy);
      end
    end
    if (d[1] && m_act != l8) begin
      if (m_act != NONE) m_req[loc] = 1'b1;
      else newa = l8;
    end
    if (setnew) m_xfer(newa);
  endtask

  function automatic logic [7:0] exp_byte(int i);
    logic [7:0] b;
    bit p;
    p = 0;
    for (int j = 0; j < N; j++) if (j != i && m_req[j]) p = 1;
    b = 8'h80;
    b[5] = (m_act == 8'(i));
    b[4] = m_seized[i];
    b[2] = p;
    b[1] = m_req[i];
    return b;
  endfunction

  task automatic compare(string tag);
    check(owner == m_act, {tag, " owner"}, 32'(owner), 32'(m_act));
    check(owner_changed == m_chg, {tag, " owner_changed"}, 32'(owner_changed), 32'(m_chg));
    check(abort_req == m_abt, {tag, " abort_req"}, 32'(abort_req), 32'(m_abt));
    for (int i = 0; i < N; i++)
      check(acc_rdata[i*8 +: 8] == exp_byte(i), {tag, " access byte"},
            32'(acc_rdata[i*8 +: 8]), 32'(exp_byte(i)));
  endtask

  task automatic step(int loc, logic [11:0] off, logic [7:0] d, bit en,
                      bit busy, bit done, string tag);
    @(negedge clk);
    wr_en = en; wr_addr = {loc[2:0], off}; wr_data = d;
    cmd_busy = busy; abort_done = done;
    m_chg = 0; m_abt = 0;
    if (m_pend && done) begin m_xfer(m_next); m_pend = 0; m_next = NONE; end
    if (en && off == 0 && loc < N && loc != 4) m_write(loc, d, busy);
    @(negedge clk);
    wr_en = 0; abort_done = 0;
    compare(tag);
  endtask

  task automatic wr(int loc, logic [7:0] d, bit busy, string tag);
    step(loc, 12'h000, d, 1'b1, busy, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_req = '0; m_seize = '0; m_seized = '0; m_act = NONE; m_next = NONE;
    m_pend = 0; m_chg = 0; m_abt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(owner == NONE, "R1 owner", 32'(owner), 32'hFF);
    for (int i = 0; i < N; i++)
      check(acc_rdata[i*8 +: 8] == 8'h80, "R1 access byte", 32'(acc_rdata[i*8 +: 8]), 32'h80);

    wr(0, 8'h02, 0, "R3");
    check(owner == 8'd0 && owner_changed, "R3 claim", 32'(owner), 32'd0);
    wr(2, 8'h02, 0, "R4");
    check(acc_rdata[7:0] == 8'hA4, "R4 R2 pending seen by owner", 32'(acc_rdata[7:0]), 32'hA4);
    wr(3, 8'h02, 0, "R4");
    wr(0, 8'h02, 0, "R4 owner request");
    wr(0, 8'h20, 0, "R5");
    check(owner == 8'd3, "R5 highest requester", 32'(owner), 32'd3);
    wr(2, 8'h20, 0, "R6");
    check(acc_rdata[23:16] == 8'h80, "R6 request dropped", 32'(acc_rdata[23:16]), 32'h80);
    wr(1, 8'h08, 0, "R7 lower seize refused");
    wr(4, 8'h02, 0, "R11 page 4");
    step(3, 12'h004, 8'h20, 1, 0, 0, "R11 offset");
    step(6, 12'h000, 8'h02, 1, 0, 0, "R11 page 6");
    wr(3, 8'h20, 0, "R5 release to none");
    check(owner == NONE, "R5 none left", 32'(owner), 32'hFF);
    wr(1, 8'h02, 0, "R3");
    wr(2, 8'h08, 0, "R8");
    check(acc_rdata[15:8] == 8'h90, "R8 been-seized", 32'(acc_rdata[15:8]), 32'h90);
    wr(1, 8'h10, 0, "R8 clear");
    wr(3, 8'h0A, 0, "R12");
    check(acc_rdata[31:24] == 8'hA0, "R12 request ignored", 32'(acc_rdata[31:24]), 32'hA0);
    wr(0, 8'h02, 0, "R4");
    wr(3, 8'h20, 1, "R10 deferred");
    check(owner == 8'd3 && abort_req, "R10 abort raised", 32'(owner), 32'd3);
    step(0, 0, 8'h00, 0, 1, 0, "R10 waiting");
    step(0, 0, 8'h00, 0, 0, 1, "R10 done");
    check(owner == 8'd0, "R10 moved", 32'(owner), 32'd0);
    wr(1, 8'h08, 1, "R7");
    wr(2, 8'h08, 1, "R7 cancels lower");
    wr(1, 8'h08, 1, "R7 higher pending");
    step(0, 0, 8'h00, 0, 0, 1, "R9 seize done");
    check(owner == 8'd2, "R9 seizer owns", 32'(owner), 32'd2);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      int loc;
      logic [11:0] off;
      loc = int'($urandom % 8);
      off = ($urandom % 8 == 0) ? 12'($urandom) : 12'h000;
      step(loc, off, 8'($urandom), ($urandom % 4) != 0, ($urandom % 2) != 0,
           ($urandom % 3) == 0, "R9 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule